// File: doc/BRIEF.md
# Control Endpoint Status Register Logic

This block holds the control and status bits of a USB device's endpoint 0. A processor reads and writes three small registers over a simple synchronous bus. The USB protocol engine feeds it single-cycle event pulses: an IN packet went out, a control OUT packet arrived, a stall handshake was sent, and a remote-wakeup feature request was decoded as set or clear. In return the block tells the engine that an IN packet is ready and that a stall is wanted, flushes the transmit FIFO, and raises an endpoint-0 interrupt that a mask bit gates.

The bits follow mixed ownership rules. Some are set by software and cleared by hardware. Some are write-one-to-clear. One is a strobe that always reads zero, and some are read-only mirrors of hardware state. Hardware events can also start a flush or raise the interrupt. When a hardware event and a software write hit the same bit in the same cycle, the hardware action wins.

Register map (`csr_addr_i`): 0 = control/status, 1 = interrupt mask (bit 0, 1 = enabled), 2 = interrupt status (bit 0, write-one-to-clear), 3 = unused. Control/status bit positions: 0 in-ready, 1 flush, 2 force-stall, 3 sent-stall, 4 rx-not-empty, 5 remote-wakeup.

Top module: `ep0_csr_top`

## Requirements
- R1: After reset every stored bit is zero: `in_ready_o`, `stall_req_o`, `tx_flush_o` and `irq_o` are low, and all register reads return zero apart from the live rx-not-empty bit.
- R2: Writing 1 to bit 0 at address 0 sets in-ready, so `in_ready_o` is high from the next cycle. Writing 0 there has no effect, and bit 0 always reads as 0.
- R3: In-ready is cleared by `in_done_i`, by `out_rcvd_i`, or by any flush trigger. A hardware clear wins over a software set in the same cycle.
- R4: A flush trigger makes `tx_flush_o` high for exactly the next cycle. The triggers are writing 1 to bit 1 at address 0, `out_rcvd_i`, and sent-stall being set. Bit 1 always reads as 0.
- R5: Remote-wakeup (bit 5 at address 0) is set by `feat_set_i` and cleared by `feat_clr_i`, with clear winning if both arrive together. Bus writes do not change it.
- R6: Writing 1 to bit 2 at address 0 sets force-stall, which drives `stall_req_o`. `stall_sent_i` while force-stall is set clears it. Writing 0 has no effect.
- R7: Sent-stall (bit 3) is set only by `stall_sent_i` while force-stall is set. A `stall_sent_i` with force-stall clear, such as an automatic protocol stall, changes nothing. Writing 1 to bit 3 clears it, and a hardware set wins over that clear.
- R8: Bit 4 at address 0 reads the live value of `rx_nonempty_i`.
- R9: When in-ready is set and `in_done_i` or `out_rcvd_i` clears it, the interrupt status (and `irq_o`) rises on the same edge, provided the mask is enabled. A flush-only clear raises no interrupt.
- R10: The mask is read/write at address 2'd1 bit 0. Writing 1 to bit 0 at address 2 clears the interrupt status, and a same-cycle hardware set wins. While the mask is 0, the status is forced to 0 on the next edge.
- R11: Writes to address 3 change nothing, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 2 | Register address |
| csr_wdata_i | input | DATA_W | Write data |
| csr_rdata_o | output | DATA_W | Read data for csr_addr_i (combinational) |
| in_done_i | input | 1 | IN packet sent successfully |
| out_rcvd_i | input | 1 | Control OUT packet received |
| stall_sent_i | input | 1 | Stall handshake sent on the bus |
| feat_set_i | input | 1 | Remote-wakeup feature set decoded |
| feat_clr_i | input | 1 | Remote-wakeup feature clear decoded |
| rx_nonempty_i | input | 1 | Receive FIFO holds unread data |
| in_ready_o | output | 1 | IN packet ready for the engine |
| stall_req_o | output | 1 | Stall request to the engine |
| tx_flush_o | output | 1 | One-cycle transmit FIFO flush |
| irq_o | output | 1 | Endpoint-0 interrupt |

## Verification
Every stored bit, the flush pulse and the interrupt take effect on the first clock edge after the stimulus is seen, so they are due one cycle later. The read data is combinational: it reflects the current address and state with no delay. The reference model in the bench updates on the same edge as the design and is compared at the falling edge of every cycle, while the stimulus changes just after the rising edge. Directed checks sample a few nanoseconds after the edge that registers the result, and they check the flush pulse again one cycle later to confirm it has gone low.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CS   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INT  = 2'd2;

  localparam int unsigned B_IN_RDY = 0;
  localparam int unsigned B_FLUSH  = 1;
  localparam int unsigned B_FORCE  = 2;
  localparam int unsigned B_SENT   = 3;
  localparam int unsigned B_RXNE   = 4;
  localparam int unsigned B_RWAKE  = 5;
  localparam int unsigned B_IRQ    = 0;
  localparam int unsigned MIN_DATA_W = B_RWAKE + 1;

  typedef struct packed {
    logic in_done;
    logic out_rcvd;
    logic stall_sent;
    logic feat_set;
    logic feat_clr;
  } ep0_evt_t;

  typedef struct packed {
    logic in_rdy_set;
    logic flush_req;
    logic force_set;
    logic sent_clr;
    logic mask_we;
    logic mask_val;
    logic irq_clr;
  } ep0_sw_t;
endpackage

// File: rtl/ep0_bus_decode.sv
module ep0_bus_decode
  import ep0_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ep0_sw_t           sw_o
);
  logic cs_we, mask_we, int_we;

  assign cs_we   = we_i && (addr_i == ADDR_CS);
  assign mask_we = we_i && (addr_i == ADDR_MASK);
  assign int_we  = we_i && (addr_i == ADDR_INT);

  always_comb begin
    sw_o            = '0;
    sw_o.in_rdy_set = cs_we & wdata_i[B_IN_RDY];
    sw_o.flush_req  = cs_we & wdata_i[B_FLUSH];
    sw_o.force_set  = cs_we & wdata_i[B_FORCE];
    sw_o.sent_clr   = cs_we & wdata_i[B_SENT];
    sw_o.mask_we    = mask_we;
    sw_o.mask_val   = wdata_i[B_IRQ];
    sw_o.irq_clr    = int_we & wdata_i[B_IRQ];
  end
endmodule

// File: rtl/ep0_status_bits.sv
module ep0_status_bits
  import ep0_csr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ep0_sw_t  sw_i,
  input  ep0_evt_t evt_i,
  output logic     in_rdy_o,
  output logic     force_o,
  output logic     sent_o,
  output logic     rwake_o,
  output logic     flush_o,
  output logic     irq_evt_o
);
  logic in_rdy_q, force_q, sent_q, rwake_q, flush_q;
  logic stall_done, flush_trig, in_hw_clr;

  // only a stall that software forced counts as sent-stall
  assign stall_done = evt_i.stall_sent & force_q;
  assign flush_trig = sw_i.flush_req | evt_i.out_rcvd | stall_done;
  assign in_hw_clr  = evt_i.in_done | evt_i.out_rcvd | flush_trig;
  assign irq_evt_o  = (evt_i.in_done | evt_i.out_rcvd) & in_rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rdy_q <= 1'b0;
      force_q  <= 1'b0;
      sent_q   <= 1'b0;
      rwake_q  <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= flush_trig;

      if (in_hw_clr)            in_rdy_q <= 1'b0;
      else if (sw_i.in_rdy_set) in_rdy_q <= 1'b1;

      if (stall_done)          force_q <= 1'b0;
      else if (sw_i.force_set) force_q <= 1'b1;

      if (stall_done)         sent_q <= 1'b1;
      else if (sw_i.sent_clr) sent_q <= 1'b0;

      if (evt_i.feat_clr)      rwake_q <= 1'b0;
      else if (evt_i.feat_set) rwake_q <= 1'b1;
    end
  end

  assign in_rdy_o = in_rdy_q;
  assign force_o  = force_q;
  assign sent_o   = sent_q;
  assign rwake_o  = rwake_q;
  assign flush_o  = flush_q;
endmodule

// File: rtl/ep0_irq.sv
module ep0_irq
  import ep0_csr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ep0_sw_t sw_i,
  input  logic    irq_evt_i,
  output logic    mask_o,
  output logic    irq_o
);
  logic mask_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (sw_i.mask_we) mask_q <= sw_i.mask_val;

      if (!mask_q)           irq_q <= 1'b0;
      else if (irq_evt_i)    irq_q <= 1'b1;
      else if (sw_i.irq_clr) irq_q <= 1'b0;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ep0_rd_mux.sv
module ep0_rd_mux
  import ep0_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              force_i,
  input  logic              sent_i,
  input  logic              rxne_i,
  input  logic              rwake_i,
  input  logic              mask_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CS: begin
        rdata_o[B_FORCE] = force_i;
        rdata_o[B_SENT]  = sent_i;
        rdata_o[B_RXNE]  = rxne_i;
        rdata_o[B_RWAKE] = rwake_i;
      end
      ADDR_MASK: rdata_o[B_IRQ] = mask_i;
      ADDR_INT:  rdata_o[B_IRQ] = irq_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ep0_csr_top.sv
module ep0_csr_top
  import ep0_csr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_addr_i,
  input  logic [DATA_W-1:0] csr_wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  input  logic              in_done_i,
  input  logic              out_rcvd_i,
  input  logic              stall_sent_i,
  input  logic              feat_set_i,
  input  logic              feat_clr_i,
  input  logic              rx_nonempty_i,
  output logic              in_ready_o,
  output logic              stall_req_o,
  output logic              tx_flush_o,
  output logic              irq_o
);
  ep0_sw_t  sw;
  ep0_evt_t evt;
  logic     sent_stall_q, rwake_q, irq_mask_q, irq_evt;

  if (DATA_W < MIN_DATA_W) begin : g_bad_width
    initial $error("DATA_W too small");
  end

  assign evt.in_done    = in_done_i;
  assign evt.out_rcvd   = out_rcvd_i;
  assign evt.stall_sent = stall_sent_i;
  assign evt.feat_set   = feat_set_i;
  assign evt.feat_clr   = feat_clr_i;

  ep0_bus_decode #(.DATA_W(DATA_W)) u_dec (
    .we_i    (csr_we_i),
    .addr_i  (csr_addr_i),
    .wdata_i (csr_wdata_i),
    .sw_o    (sw)
  );

  ep0_status_bits u_bits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_i      (sw),
    .evt_i     (evt),
    .in_rdy_o  (in_ready_o),
    .force_o   (stall_req_o),
    .sent_o    (sent_stall_q),
    .rwake_o   (rwake_q),
    .flush_o   (tx_flush_o),
    .irq_evt_o (irq_evt)
  );

  ep0_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_i      (sw),
    .irq_evt_i (irq_evt),
    .mask_o    (irq_mask_q),
    .irq_o     (irq_o)
  );

  ep0_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .addr_i  (csr_addr_i),
    .force_i (stall_req_o),
    .sent_i  (sent_stall_q),
    .rxne_i  (rx_nonempty_i),
    .rwake_i (rwake_q),
    .mask_i  (irq_mask_q),
    .irq_i   (irq_o),
    .rdata_o (csr_rdata_o)
  );
endmodule

// File: rtl/ep0_csr_chk.sv
module ep0_csr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_done_i,
  input logic out_rcvd_i,
  input logic stall_sent_i,
  input logic feat_set_i,
  input logic feat_clr_i,
  input logic in_ready_o,
  input logic stall_req_o,
  input logic tx_flush_o,
  input logic irq_o,
  input logic sent_q,
  input logic rwake_q,
  input logic mask_q
);
  // R3
  a_r3_hw_clears_in_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_done_i || out_rcvd_i) |=> !in_ready_o);
  // R4
  a_r4_out_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_rcvd_i |=> tx_flush_o);
  // R5
  a_r5_rwake_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feat_set_i && !feat_clr_i) |=> rwake_q);
  a_r5_rwake_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_clr_i |=> !rwake_q);
  // R6
  a_r6_stall_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_sent_i && stall_req_o) |=> !stall_req_o);
  // R7
  a_r7_sent_needs_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sent_q) |-> $past(stall_sent_i && stall_req_o));
  a_r7_sent_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sent_q) |-> tx_flush_o);
  // R9
  a_r9_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((in_done_i || out_rcvd_i) && in_ready_o));
  // R10
  a_r10_mask_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q |=> !irq_o);
endmodule

bind ep0_csr_top ep0_csr_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_done_i    (in_done_i),
  .out_rcvd_i   (out_rcvd_i),
  .stall_sent_i (stall_sent_i),
  .feat_set_i   (feat_set_i),
  .feat_clr_i   (feat_clr_i),
  .in_ready_o   (in_ready_o),
  .stall_req_o  (stall_req_o),
  .tx_flush_o   (tx_flush_o),
  .irq_o        (irq_o),
  .sent_q       (sent_stall_q),
  .rwake_q      (rwake_q),
  .mask_q       (irq_mask_q)
);

// File: tb/ep0_csr_top_bench.sv
`timescale 1ns/1ps
module ep0_csr_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       in_done = 1'b0, out_rcvd = 1'b0, stall_sent = 1'b0;
  logic       feat_set = 1'b0, feat_clr = 1'b0, rxne = 1'b0;
  logic [7:0] rdata;
  logic       in_ready, stall_req, tx_flush, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit m_in, m_force, m_sent, m_rw, m_flush, m_mask, m_int;

  always #10 clk = ~clk;

  ep0_csr_top u_ep0_csr_top (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .in_done_i(in_done),
    .out_rcvd_i(out_rcvd), .stall_sent_i(stall_sent), .feat_set_i(feat_set),
    .feat_clr_i(feat_clr), .rx_nonempty_i(rxne), .in_ready_o(in_ready),
    .stall_req_o(stall_req), .tx_flush_o(tx_flush), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rdata(input logic [1:0] a);
    case (a)
      2'd0: return (int'(m_rw) << 5) | (int'(rxne) << 4) | (int'(m_sent) << 3) | (int'(m_force) << 2);
      2'd1: return int'(m_mask);
      2'd2: return int'(m_int);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in = 0; m_force = 0; m_sent = 0; m_rw = 0; m_flush = 0; m_mask = 0; m_int = 0;
    end else begin
      bit w0, w1, w2, stall_ok, ftrig, ev;
      w0 = we && addr == 2'd0;
      w1 = we && addr == 2'd1;
      w2 = we && addr == 2'd2;
      stall_ok = stall_sent && m_force;
      ftrig = (w0 && wdata[1]) || out_rcvd || stall_ok;
      ev = (in_done || out_rcvd) && m_in;
      m_int = !m_mask ? 1'b0 : ev ? 1'b1 : (w2 && wdata[0]) ? 1'b0 : m_int;
      if (w1) m_mask = wdata[0];
      m_in = (in_done || out_rcvd || ftrig) ? 1'b0 : (w0 && wdata[0]) ? 1'b1 : m_in;
      m_sent = stall_ok ? 1'b1 : (w0 && wdata[3]) ? 1'b0 : m_sent;
      m_force = stall_ok ? 1'b0 : (w0 && wdata[2]) ? 1'b1 : m_force;
      m_rw = feat_clr ? 1'b0 : feat_set ? 1'b1 : m_rw;
      m_flush = ftrig;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R3 in_ready", in_ready, m_in);
      chk("R6 stall_req", stall_req, m_force);
      chk("R4 tx_flush", tx_flush, m_flush);
      chk("R9/R10 irq", irq, m_int);
      chk("R11 rdata", rdata, exp_rdata(addr));
    end
  end

  task automatic step();
    @(posedge clk); #2;
    we = 0; in_done = 0; out_rcvd = 0; stall_sent = 0; feat_set = 0; feat_clr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d;
    step();
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = rdata;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 in_ready", in_ready, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flush", tx_flush, 0);
    chk("R1 stall", stall_req, 0);
    rd(2'd0, v); chk("R1 rd cs", v, 0);
    rst_n = 1'b1;
    step();

    wr(2'd1, 8'h01); rd(2'd1, v); chk("R10 mask rd", v, 1);
    wr(2'd0, 8'h01); chk("R2 set in_rdy", in_ready, 1);
    rd(2'd0, v); chk("R2 in_rdy reads 0", v & 1, 0);
    wr(2'd0, 8'h00); chk("R2 zero write", in_ready, 1);
    in_done = 1; step();
    chk("R3 in_done clears", in_ready, 0);
    chk("R9 irq raised", irq, 1);
    wr(2'd2, 8'h00); chk("R10 zero no clear", irq, 1);
    wr(2'd2, 8'h01); chk("R10 w1c", irq, 0);

    wr(2'd0, 8'h01);
    wr(2'd0, 8'h02);
    chk("R4 flush pulse", tx_flush, 1);
    chk("R3 flush clears", in_ready, 0);
    chk("R9 no irq on flush", irq, 0);
    rd(2'd0, v); chk("R4 flush reads 0", v & 2, 0);
    step(); chk("R4 flush one cycle", tx_flush, 0);

    we = 1; addr = 2'd0; wdata = 8'h01; in_done = 1; step();
    chk("R3 hw wins", in_ready, 0);

    wr(2'd0, 8'h01);
    out_rcvd = 1; step();
    chk("R4 out flush", tx_flush, 1);
    chk("R3 out clears", in_ready, 0);
    chk("R9 out irq", irq, 1);
    wr(2'd0, 8'h01);
    we = 1; addr = 2'd2; wdata = 8'h01; in_done = 1; step();
    chk("R10 hw set wins", irq, 1);
    wr(2'd2, 8'h01);

    wr(2'd0, 8'h04); chk("R6 force", stall_req, 1);
    wr(2'd0, 8'h00); chk("R6 zero write", stall_req, 1);
    stall_sent = 1; step();
    chk("R6 self clear", stall_req, 0);
    chk("R7 sent flush", tx_flush, 1);
    rd(2'd0, v); chk("R7 sent set", (v >> 3) & 1, 1);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R7 zero keeps", (v >> 3) & 1, 1);
    wr(2'd0, 8'h08); rd(2'd0, v); chk("R7 w1c", (v >> 3) & 1, 0);
    stall_sent = 1; step();
    rd(2'd0, v); chk("R7 auto stall ignored", (v >> 3) & 1, 0);
    chk("R7 auto no flush", tx_flush, 0);

    feat_set = 1; step(); rd(2'd0, v); chk("R5 set", (v >> 5) & 1, 1);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R5 write ignored", (v >> 5) & 1, 1);
    feat_set = 1; feat_clr = 1; step(); rd(2'd0, v); chk("R5 clr wins", (v >> 5) & 1, 0);

    rxne = 1; rd(2'd0, v); chk("R8 rxne 1", (v >> 4) & 1, 1);
    rxne = 0; rd(2'd0, v); chk("R8 rxne 0", (v >> 4) & 1, 0);

    wr(2'd0, 8'h01); in_done = 1; step(); chk("R9 pending", irq, 1);
    wr(2'd1, 8'h00); step(); chk("R10 mask forces 0", irq, 0);
    wr(2'd0, 8'h01); in_done = 1; step(); chk("R9 masked", irq, 0);

    wr(2'd3, 8'hFF);
    chk("R11 addr3 in_rdy", in_ready, 0);
    chk("R11 addr3 stall", stall_req, 0);
    rd(2'd3, v); chk("R11 addr3 reads 0", v, 0);

    for (int i = 0; i < 4000; i++) begin
      we = ($urandom % 3) == 0;
      addr = 2'($urandom);
      wdata = 8'($urandom);
      in_done = ($urandom % 6) == 0;
      out_rcvd = ($urandom % 9) == 0;
      stall_sent = ($urandom % 5) == 0;
      feat_set = ($urandom % 7) == 0;
      feat_clr = ($urandom % 7) == 0;
      rxne = 1'($urandom);
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule